// File: doc/BRIEF.md
# Folded Dense Layer with Shared Multipliers

This block computes one fully connected neural-network layer: it takes a vector of `N_IN` signed 8-bit features and produces `N_OUT` signed 32-bit results. Each result is a weighted sum of all inputs plus a bias. A ReLU clamp can be applied to the result. The weights and biases are constants fixed at elaboration and held on chip.

The layer does not give every product its own multiplier. A bank of `N_IN*N_OUT/REUSE` multipliers is shared across all the products over `REUSE` consecutive cycles. Each multiplier owns a fixed, contiguous slice of the product list. Halving `REUSE` doubles the multiplier bank and halves the time spent multiplying. A `REUSE` that does not divide the product count evenly stops elaboration.

Vectors enter and leave through valid/ready handshakes. The layer handles one vector at a time. It refuses new input until the current result has been taken.

Top module: `folded_dense`

## Requirements
- R1: After reset, `inReady` is 1 and `outValid` is 0.
- R2: Output lane o (bits `[32*o +: 32]` of `outData`) equals bias(o) + sum over i of w(o,i)*x(i). Input lane i is bits `[8*i +: 8]` of `inData`, read as two's complement. w(o,i) is ((37*o + 11*i + 5) mod 256) read as an 8-bit two's complement value. bias(o) = 50*o - 75.
- R3: With `USE_RELU`=1 (the default), a lane whose R2 value is negative is presented as 0. Non-negative lanes pass through unchanged.
- R4: `outValid` rises exactly `REUSE`+2 clock edges after the edge that accepts an input vector (`inValid` and `inReady` both high).
- R5: `inReady` is low from the accepting edge until the edge at which the output is taken. While it is low, `inValid` and `inData` have no effect on any result.
- R6: While `outValid` is high and `outReady` is low, `outValid` stays high and `outData` does not change. The output is taken on an edge where both are high, and `inReady` returns to 1 after that edge.
- R7: The accumulators start from zero for every vector. A vector sent right after another yields only its own R2 result.
- R8: Extreme operands (all lanes -128 or all lanes 127) give the exact R2 result without wrap-around in 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| inValid | input | 1 | Input vector present |
| inReady | output | 1 | Layer can accept a vector |
| inData | input | 8*N_IN | Packed signed input features |
| outValid | output | 1 | Result vector present |
| outReady | input | 1 | Consumer takes the result |
| outData | output | 32*N_OUT | Packed signed results |

## Verification
A wrong step count or a bad multiplier-to-product mapping makes at least one output lane differ from the weighted sum. This shows up on the first vector presented, at the cycle where `outValid` rises. A stale accumulator shows up only on the second vector of a sequence, so results are compared across back-to-back vectors. A faulty sequencer shows up in the same cycle as a handshake flag that differs from the reference model's flag. An extra or missing stage is caught at the one cycle where `outValid` should rise. A leak of input taken while the layer is busy changes the following result.

// File: rtl/dense_pkg.sv
package dense_pkg;

  typedef struct packed {
    logic        load;     // latch features, clear sums
    logic        accum;    // add this step's products
    logic        addBias;  // fold in the bias
    logic        outLoad;  // capture clamped result
    logic [15:0] step;     // current reuse step
  } ctlStrobes_t;

  function automatic logic signed [7:0] weightAt(input int o, input int i);
    int v;
    v = (37 * o + 11 * i + 5) % 256;
    return v[7:0];
  endfunction

  function automatic logic signed [31:0] biasAt(input int o);
    return 32'(50 * o - 75);
  endfunction

endpackage

// File: rtl/fold_control.sv
module fold_control #(
  parameter int REUSE = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       inValid,
  output logic                       inReady,
  output logic                       outValid,
  input  logic                       outReady,
  output dense_pkg::ctlStrobes_t     ctl
);
  localparam int LW = $clog2(REUSE + 3) + 1;

  typedef enum logic [2:0] {S_IDLE, S_RUN, S_BIAS, S_LOAD, S_HOLD} state_t;
  state_t      state;
  logic [15:0] step;
  logic [LW-1:0] latCnt;

  assign inReady  = (state == S_IDLE);
  assign outValid = (state == S_HOLD);

  always_comb begin
    ctl         = '0;
    ctl.load    = inValid && (state == S_IDLE);
    ctl.accum   = (state == S_RUN);
    ctl.addBias = (state == S_BIAS);
    ctl.outLoad = (state == S_LOAD);
    ctl.step    = step;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      step  <= '0;
    end else begin
      case (state)
        S_IDLE: if (inValid) begin
          state <= S_RUN;
          step  <= '0;
        end
        S_RUN: begin
          if (step == 16'(REUSE - 1)) state <= S_BIAS;
          else                        step  <= step + 16'd1;
        end
        S_BIAS:  state <= S_LOAD;
        S_LOAD:  state <= S_HOLD;
        S_HOLD:  if (outReady) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // cycles since acceptance, used only by the latency check
  always_ff @(posedge clk) begin
    if (!rstN)                               latCnt <= '0;
    else if (ctl.load)                       latCnt <= '0;
    else if (state != S_HOLD && state != S_IDLE) latCnt <= latCnt + 1'b1;
  end

  p_busy_r5: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> !inReady);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid);

  p_latency_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> (latCnt == LW'(REUSE + 2)));

  p_step_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.accum |-> (ctl.step < 16'(REUSE)));

endmodule

// File: rtl/fold_datapath.sv
module fold_datapath #(
  parameter int N_IN     = 4,
  parameter int N_OUT    = 4,
  parameter int REUSE    = 4,
  parameter bit USE_RELU = 1'b1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  dense_pkg::ctlStrobes_t     ctl,
  input  logic [8*N_IN-1:0]          inData,
  output logic [32*N_OUT-1:0]        outData
);
  localparam int NPROD = N_IN * N_OUT;
  localparam int NMUL  = NPROD / REUSE;
  localparam int SW    = (REUSE > 1) ? $clog2(REUSE) : 1;
  localparam int IW    = (N_IN > 1) ? $clog2(N_IN) : 1;

  logic signed [7:0]  xReg    [N_IN];
  logic signed [31:0] acc     [N_OUT];
  logic signed [31:0] outReg  [N_OUT];
  logic signed [15:0] prod    [NMUL];
  int                 oSel    [NMUL];
  logic signed [31:0] partial [N_OUT];

  for (genvar m = 0; m < NMUL; m++) begin : g_mul
    logic signed [7:0] wRom [REUSE];
    logic [IW-1:0]     iIdx;
    logic [SW-1:0]     sIdx;
    int                p;

    always_comb begin
      for (int k = 0; k < REUSE; k++)
        wRom[k] = dense_pkg::weightAt((m * REUSE + k) / N_IN, (m * REUSE + k) % N_IN);
    end

    always_comb begin
      sIdx    = ctl.step[SW-1:0];
      p       = m * REUSE + int'(ctl.step);
      oSel[m] = p / N_IN;
      iIdx    = IW'(p % N_IN);
      prod[m] = wRom[sIdx] * xReg[iIdx];
    end
  end

  always_comb begin
    for (int o = 0; o < N_OUT; o++) begin
      partial[o] = '0;
      for (int m = 0; m < NMUL; m++)
        if (oSel[m] == o) partial[o] = partial[o] + 32'(prod[m]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < N_IN; i++)  xReg[i] <= '0;
      for (int o = 0; o < N_OUT; o++) begin
        acc[o]    <= '0;
        outReg[o] <= '0;
      end
    end else begin
      if (ctl.load) begin
        for (int i = 0; i < N_IN; i++)  xReg[i] <= inData[8*i +: 8];
        for (int o = 0; o < N_OUT; o++) acc[o]  <= '0;
      end
      if (ctl.accum)
        for (int o = 0; o < N_OUT; o++) acc[o] <= acc[o] + partial[o];
      if (ctl.addBias)
        for (int o = 0; o < N_OUT; o++) acc[o] <= acc[o] + dense_pkg::biasAt(o);
      if (ctl.outLoad)
        for (int o = 0; o < N_OUT; o++)
          outReg[o] <= (USE_RELU && acc[o] < 0) ? 32'sd0 : acc[o];
    end
  end

  for (genvar o = 0; o < N_OUT; o++) begin : g_pack
    assign outData[32*o +: 32] = outReg[o];
  end

  p_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> (acc[0] == 32'sd0));

endmodule

// File: rtl/folded_dense.sv
module folded_dense #(
  parameter int N_IN     = 4,
  parameter int N_OUT    = 4,
  parameter int REUSE    = 4,
  parameter bit USE_RELU = 1'b1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  output logic                 inReady,
  input  logic [8*N_IN-1:0]    inData,
  output logic                 outValid,
  input  logic                 outReady,
  output logic [32*N_OUT-1:0]  outData
);
  if ((N_IN * N_OUT) % REUSE != 0) begin : g_bad_reuse
    $error("REUSE must divide N_IN*N_OUT");
  end

  dense_pkg::ctlStrobes_t ctl;

  fold_control #(.REUSE(REUSE)) u_ctl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .outValid(outValid), .outReady(outReady), .ctl(ctl)
  );

  fold_datapath #(.N_IN(N_IN), .N_OUT(N_OUT), .REUSE(REUSE), .USE_RELU(USE_RELU)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .inData(inData), .outData(outData)
  );

  p_stable_r6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> $stable(outData));

endmodule

// File: tb/folded_dense_test.sv
module folded_dense_test;
  localparam int NI = 4;
  localparam int NO = 4;
  localparam int RF = 4;

  logic clk = 0;
  logic rstN = 0;
  logic inValid = 0;
  logic outReady = 0;
  logic [8*NI-1:0]  inData = '0;
  logic             inReady, outValid;
  logic [32*NO-1:0] outData;

  int compared = 0;
  int mismatched = 0;
  string curTag = "R2";

  folded_dense #(.N_IN(NI), .N_OUT(NO), .REUSE(RF), .USE_RELU(1'b1)) uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inData(inData),
    .outValid(outValid), .outReady(outReady), .outData(outData)
  );

  always #5 clk = ~clk;

  function automatic int wRef(int o, int i);
    int v = (37 * o + 11 * i + 5) % 256;
    return (v > 127) ? v - 256 : v;
  endfunction

  function automatic logic [32*NO-1:0] refLayer(logic [8*NI-1:0] x);
    logic [32*NO-1:0] r;
    for (int o = 0; o < NO; o++) begin
      int s = 50 * o - 75;
      for (int i = 0; i < NI; i++) s += wRef(o, i) * int'($signed(x[8*i +: 8]));
      if (s < 0) s = 0;  // R3 clamp
      r[32*o +: 32] = 32'(s);
    end
    return r;
  endfunction

  // behavioural reference: 0 idle, 1 busy, 2 presenting
  int mState = 0;
  int mCnt = 0;
  logic [32*NO-1:0] mExp = '0;

  always @(posedge clk) begin
    if (!rstN) mState = 0;
    else case (mState)
      0: if (inValid) begin mExp = refLayer(inData); mCnt = 0; mState = 1; end
      1: begin mCnt++; if (mCnt == RF + 2) mState = 2; end
      default: if (outReady) mState = 0;
    endcase
  end

  task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      check("R5 inReady", 128'(inReady), 128'(mState == 0));
      check("R4 outValid", 128'(outValid), 128'(mState == 2));
      if (mState == 2 && outValid) check(curTag, 128'(outData), 128'(mExp));
    end
  end

  task automatic runVec(logic [8*NI-1:0] x, int holdCyc, string tag);
    while (!inReady) @(negedge clk);
    curTag  = tag;
    inValid = 1; inData = x;
    @(negedge clk);
    // R5: junk offered while busy must be ignored
    inValid = 1; inData = ~x ^ 32'h5a5a_1234;
    @(negedge clk);
    @(negedge clk);
    inValid = 0;
    while (!outValid) @(negedge clk);
    outReady = 0;
    repeat (holdCyc) @(negedge clk);
    outReady = 1;
    @(negedge clk);
    outReady = 0;
  endtask

  int wdog = 0;
  always @(posedge clk) begin
    wdog++;
    if (wdog > 100000) begin
      mismatched++;
      $display("FAIL watchdog actual=%0d expected<100000", wdog);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 inReady", 128'(inReady), 128'(1));
    check("R1 outValid", 128'(outValid), 128'(0));
    rstN = 1;
    @(negedge clk);
    runVec('0, 0, "R3 zero input bias only");
    runVec({8'd1, 8'd1, 8'd1, 8'd1}, 3, "R2 ones R6 held");
    runVec({4{8'h80}}, 0, "R8 all -128");
    runVec({4{8'h7f}}, 5, "R8 all 127 R6 held");
    runVec({8'h05, 8'hfb, 8'h10, 8'hf0}, 0, "R2 mixed signs");
    // R7: back-to-back vectors
    runVec({8'h7f, 8'h7f, 8'h7f, 8'h7f}, 0, "R7 first");
    runVec({8'h01, 8'h00, 8'h00, 8'h00}, 0, "R7 second");
    for (int n = 0; n < 12; n++)
      runVec(32'($urandom()), n % 3, "R2 random");
    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule